// File: doc/BRIEF.md
# Square-Root Carry-Select Adder with Increment Converters

This block is a purely combinational 16-bit adder. It adds two operands and a single carry-in, and it returns a 16-bit sum and a carry-out. The operand bits are cut into five groups whose widths grow from the bottom: two, two, three, four and five bits. This uneven split is what makes it a square-root carry-select layout.

The lowest group is a plain ripple adder fed by the external carry-in. Each upper group computes its slice only once, with a ripple adder whose carry-in is tied to zero. The result for an incoming carry of one comes from an (n+1)-bit increment-by-one converter. That converter takes the zero-carry sum together with its carry-out, so no second ripple adder is needed. The carry leaving the group below steers a 2:1 choice between the two candidates. The choice covers both the sum bits and the group's own carry-out.

The arithmetic is split from the selection. A datapath module holds the ripple adders, the converters and the sum multiplexers. A small control module forms the chain of group carries and hands the per-group select strobes back to the datapath.

Top module: `sqrt_csel_adder`

## Requirements
- R1: For every input, the 17-bit value {cout, sum} equals a + b + cin. With all inputs zero, sum is 0 and cout is 0.
- R2: The groups occupy bits [1:0], [3:2], [6:4], [10:7] and [15:11]. Each group's slice of sum equals (a slice + b slice + carry into that group) modulo 2^n, where n is the group width.
- R3: The external cin enters only the lowest group. a=0, b=0, cin=1 gives sum 0x0001. a=0x0003, b=0, cin=1 gives sum 0x0004.
- R4: A carry can ripple across every group boundary. a=0xFFFF, b=0, cin=1 gives sum 0x0000 and cout 1. a=b=0xFFFF with cin=1 gives sum 0xFFFF and cout 1.
- R5: When the carry into an upper group is 1, the group's result is its zero-carry sum plus one. An all-ones slice therefore wraps to zero and passes a carry of 1 to the next group.
- R6: When the carry into an upper group is 0, the group's slice is a slice + b slice truncated to the group width. An all-ones slice stays all ones.
- R7: The increment converter of width W returns its W-bit input plus one, modulo 2^W. Output bit i is input bit i XOR the AND of all lower input bits.
- R8: The ripple adder unit of width W returns {carryOut, sumOut} = opA + opB + carryIn.
- R9: With known inputs, sum and cout carry no unknown bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| cin | input | 1 | Carry into the lowest group |
| sum | output | 16 | Sum bits |
| cout | output | 1 | Carry out of the highest group |

## Verification
The checker's immediate assertions assume that a, b and cin are all known. They evaluate only when none of these three inputs holds an unknown bit. They also assume that the outputs have settled for the current input values.

The bench changes all three inputs together at one clock edge and always drives defined values. It reads the results half a period later, so every assertion evaluation sees a settled, fully known input set.

The directed cases put all-ones patterns below and inside each upper group. This drives every group's incoming carry to 0 and to 1 in turn, so both multiplexer paths of each group are exercised.

// File: rtl/sqcsel_pkg.sv
package sqcsel_pkg;
  localparam int GROUP_COUNT = 5;
  localparam int BASE_WIDTH  = 2;

  // width of group g: lowest two groups share BASE_WIDTH, then one wider each step
  function automatic int groupWidth(input int g);
    return (g == 0) ? BASE_WIDTH : BASE_WIDTH + g - 1;
  endfunction

  // least significant bit position of group g
  function automatic int groupLsb(input int g);
    int acc;
    acc = 0;
    for (int i = 0; i < g; i++) acc += groupWidth(i);
    return acc;
  endfunction

  localparam int ADD_WIDTH = groupLsb(GROUP_COUNT);

  // select strobes from control to datapath, one per upper group
  typedef struct packed {
    logic [GROUP_COUNT-1:1] useInc;
  } selStrobes_t;
endpackage

// File: rtl/rca_unit.sv
module rca_unit #(
  parameter int W = 4
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         carryIn,
  output logic [W-1:0] sumOut,
  output logic         carryOut
);
  logic [W:0] chain;

  assign chain[0] = carryIn;

  for (genvar i = 0; i < W; i++) begin : bitCell
    logic halfSum;
    assign halfSum      = opA[i] ^ opB[i];
    assign sumOut[i]    = halfSum ^ chain[i];
    assign chain[i+1]   = (opA[i] & opB[i]) | (chain[i] & halfSum);
  end

  assign carryOut = chain[W];
endmodule

// File: rtl/excess1_conv.sv
module excess1_conv #(
  parameter int W = 5
) (
  input  logic [W-1:0] binIn,
  output logic [W-1:0] incOut
);
  logic [W-1:0] lowerOnes;

  assign lowerOnes[0] = 1'b1;
  for (genvar i = 1; i < W; i++) begin : prefix
    assign lowerOnes[i] = lowerOnes[i-1] & binIn[i-1];
  end

  for (genvar i = 0; i < W; i++) begin : flip
    assign incOut[i] = binIn[i] ^ lowerOnes[i];
  end
endmodule

// File: rtl/csel_datapath.sv
module csel_datapath
  import sqcsel_pkg::*;
(
  input  logic [ADD_WIDTH-1:0]   opA,
  input  logic [ADD_WIDTH-1:0]   opB,
  input  logic                   carryIn,
  input  selStrobes_t            strobes,
  output logic [ADD_WIDTH-1:0]   sumOut,
  output logic [GROUP_COUNT-1:0] carry0Vec,
  output logic [GROUP_COUNT-1:1] carry1Vec
);
  for (genvar g = 0; g < GROUP_COUNT; g++) begin : grp
    localparam int GW = groupWidth(g);
    localparam int GL = groupLsb(g);

    if (g == 0) begin : lowGroup
      rca_unit #(.W(GW)) u_rca (
        .opA     (opA[GL +: GW]),
        .opB     (opB[GL +: GW]),
        .carryIn (carryIn),
        .sumOut  (sumOut[GL +: GW]),
        .carryOut(carry0Vec[g])
      );
    end else begin : upperGroup
      logic [GW-1:0] zeroSum;
      logic          zeroCarry;
      logic [GW:0]   incRes;

      rca_unit #(.W(GW)) u_rca (
        .opA     (opA[GL +: GW]),
        .opB     (opB[GL +: GW]),
        .carryIn (1'b0),
        .sumOut  (zeroSum),
        .carryOut(zeroCarry)
      );

      excess1_conv #(.W(GW + 1)) u_inc (
        .binIn (({zeroCarry, zeroSum})),
        .incOut(incRes)
      );

      assign carry0Vec[g]     = zeroCarry;
      assign carry1Vec[g]     = incRes[GW];
      assign sumOut[GL +: GW] = strobes.useInc[g] ? incRes[GW-1:0] : zeroSum;
    end
  end
endmodule

// File: rtl/csel_control.sv
module csel_control
  import sqcsel_pkg::*;
(
  input  logic [GROUP_COUNT-1:0] carry0Vec,
  input  logic [GROUP_COUNT-1:1] carry1Vec,
  output selStrobes_t            strobes,
  output logic                   carryOut
);
  logic [GROUP_COUNT-1:0] groupCarry;

  always_comb begin
    groupCarry[0] = carry0Vec[0];
    for (int g = 1; g < GROUP_COUNT; g++) begin
      strobes.useInc[g] = groupCarry[g-1];
      groupCarry[g]     = groupCarry[g-1] ? carry1Vec[g] : carry0Vec[g];
    end
  end

  assign carryOut = groupCarry[GROUP_COUNT-1];
endmodule

// File: rtl/sqrt_csel_adder.sv
module sqrt_csel_adder
  import sqcsel_pkg::*;
(
  input  logic [ADD_WIDTH-1:0] a,
  input  logic [ADD_WIDTH-1:0] b,
  input  logic                 cin,
  output logic [ADD_WIDTH-1:0] sum,
  output logic                 cout
);
  selStrobes_t            strobes;
  logic [GROUP_COUNT-1:0] carry0Vec;
  logic [GROUP_COUNT-1:1] carry1Vec;

  csel_datapath u_datapath (
    .opA      (a),
    .opB      (b),
    .carryIn  (cin),
    .strobes  (strobes),
    .sumOut   (sum),
    .carry0Vec(carry0Vec),
    .carry1Vec(carry1Vec)
  );

  csel_control u_control (
    .carry0Vec(carry0Vec),
    .carry1Vec(carry1Vec),
    .strobes  (strobes),
    .carryOut (cout)
  );
endmodule

// File: rtl/sqrt_csel_adder_chk.sv
module sqrt_csel_adder_chk
  import sqcsel_pkg::*;
(
  input logic [ADD_WIDTH-1:0] a,
  input logic [ADD_WIDTH-1:0] b,
  input logic                 cin,
  input logic [ADD_WIDTH-1:0] sum,
  input logic                 cout
);
  logic inKnown;
  assign inKnown = !$isunknown({a, b, cin});

  always_comb begin
    if (inKnown) begin
      // R9
      known_out_chk: assert (!$isunknown({cout, sum}));
      // R1
      full_sum_chk: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{ADD_WIDTH{1'b0}}, cin}));
      // R3
      low_group_chk: assert (sum[groupWidth(0)-1:0] ==
        2'(a[groupWidth(0)-1:0] + b[groupWidth(0)-1:0] + {1'b0, cin}));
    end
  end

  for (genvar g = 1; g < GROUP_COUNT; g++) begin : grpChk
    localparam int GW = groupWidth(g);
    localparam int GL = groupLsb(g);
    logic [GL:0]   lowerSum;
    logic          carryInto;
    logic [GW:0]   sliceRaw;

    always_comb begin
      lowerSum  = {1'b0, a[GL-1:0]} + {1'b0, b[GL-1:0]} + {{GL{1'b0}}, cin};
      carryInto = lowerSum[GL];
      sliceRaw  = {1'b0, a[GL +: GW]} + {1'b0, b[GL +: GW]};
      if (inKnown) begin
        // R2
        group_slice_chk: assert (sum[GL +: GW] == GW'(sliceRaw + {{GW{1'b0}}, carryInto}));
        // R5
        if (carryInto && (sliceRaw[GW-1:0] == {GW{1'b1}}) && !sliceRaw[GW])
          wrap_one_chk: assert (sum[GL +: GW] == '0);
        // R6
        if (!carryInto)
          no_carry_chk: assert (sum[GL +: GW] == sliceRaw[GW-1:0]);
      end
    end
  end
endmodule

bind sqrt_csel_adder sqrt_csel_adder_chk u_chk (
  .a   (a),
  .b   (b),
  .cin (cin),
  .sum (sum),
  .cout(cout)
);

// File: tb/sqrt_csel_adder_bench.sv
module sqrt_csel_adder_bench;
  import sqcsel_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [15:0] a, b, sum;
  logic        cin, cout;
  logic [5:0]  convIn, convOut;
  logic [2:0]  rA, rB, rSum;
  logic        rCin, rCout;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  sqrt_csel_adder u_sqrt_csel_adder (.a(a), .b(b), .cin(cin), .sum(sum), .cout(cout));
  excess1_conv #(.W(6)) u_conv (.binIn(convIn), .incOut(convOut));
  rca_unit #(.W(3)) u_rca (.opA(rA), .opB(rB), .carryIn(rCin), .sumOut(rSum), .carryOut(rCout));

  function automatic logic [16:0] refAdd(input logic [15:0] va, vb, input logic vc);
    return {1'b0, va} + {1'b0, vb} + {16'b0, vc};
  endfunction

  function automatic logic [15:0] onesBelow(input int n);
    return (n >= 16) ? 16'hFFFF : 16'((32'd1 << n) - 1);
  endfunction

  task automatic report(input bit ok, input string tag, input logic [31:0] act, exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic applyAdd(input logic [15:0] va, vb, input logic vc);
    @(posedge clk);
    a <= va; b <= vb; cin <= vc;
    @(negedge clk);
  endtask

  task automatic checkAdd(input logic [15:0] va, vb, input logic vc, input string tag);
    logic [16:0] expv;
    applyAdd(va, vb, vc);
    expv = refAdd(va, vb, vc);
    report({cout, sum} === expv, tag, {15'b0, cout, sum}, {15'b0, expv});
  endtask

  task automatic checkSlice(input int g, input logic [15:0] expSlice, input string tag);
    logic [15:0] mask, got;
    mask = onesBelow(groupWidth(g));
    got  = (sum >> groupLsb(g)) & mask;
    report(got === expSlice, tag, {16'b0, got}, {16'b0, expSlice});
  endtask

  initial begin
    int seedDummy;
    a = '0; b = '0; cin = 1'b0;
    convIn = '0; rA = '0; rB = '0; rCin = 1'b0;
    seedDummy = $urandom(32'd24681357);

    // R1: all-zero inputs
    checkAdd(16'h0000, 16'h0000, 1'b0, "R1 zero");

    // R3: external carry enters lowest group
    checkAdd(16'h0000, 16'h0000, 1'b1, "R3 cin only");
    checkAdd(16'h0003, 16'h0000, 1'b1, "R3 low wrap");

    // R4: full-width ripple
    checkAdd(16'hFFFF, 16'h0000, 1'b1, "R4 ones plus cin");
    checkAdd(16'hFFFF, 16'hFFFF, 1'b1, "R4 both ones");
    checkAdd(16'hFFFF, 16'hFFFF, 1'b0, "R4 both ones no cin");

    // R5 / R6 per upper group, both select paths
    for (int g = 1; g < GROUP_COUNT; g++) begin
      logic [15:0] pat;
      pat = onesBelow(groupLsb(g) + groupWidth(g));
      checkAdd(pat, 16'h0000, 1'b1, "R5 group carry one");
      checkSlice(g, 16'h0000, "R5 slice wraps");
      checkAdd(pat, 16'h0000, 1'b0, "R6 group carry zero");
      checkSlice(g, onesBelow(groupWidth(g)), "R6 slice stays");
      // carry into group from operand b only, group slice zero
      checkAdd(onesBelow(groupLsb(g)), 16'h0001, 1'b0, "R5 carry into empty slice");
      checkSlice(g, 16'h0001, "R5 slice plus one");
    end

    // R2: random vectors with per-group slice check
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] va, vb;
      logic vc;
      logic [16:0] expv;
      va = 16'($urandom); vb = 16'($urandom); vc = 1'($urandom);
      if (i % 7 == 0) va = va | 16'hF0F0;
      if (i % 11 == 0) vb = ~va;
      checkAdd(va, vb, vc, "R1 random");
      expv = refAdd(va, vb, vc);
      if (i % 50 == 0) begin
        for (int g = 0; g < GROUP_COUNT; g++)
          checkSlice(g, (expv[15:0] >> groupLsb(g)) & onesBelow(groupWidth(g)), "R2 group slice");
      end
    end

    // R7: converter unit, exhaustive
    for (int v = 0; v < 64; v++) begin
      @(posedge clk); convIn <= 6'(v);
      @(negedge clk);
      report(convOut === 6'(v + 1), "R7 increment", {26'b0, convOut}, 32'(6'(v + 1)));
    end

    // R8: ripple unit, exhaustive
    for (int v = 0; v < 128; v++) begin
      logic [3:0] expr;
      @(posedge clk); {rCin, rA, rB} <= 7'(v);
      @(negedge clk);
      expr = {1'b0, rA} + {1'b0, rB} + {3'b0, rCin};
      report({rCout, rSum} === expr, "R8 ripple", {28'b0, rCout, rSum}, {28'b0, expr});
    end

    // R9: known outputs for a known input
    applyAdd(16'h1234, 16'hEDCB, 1'b1);
    report(!$isunknown({cout, sum}), "R9 known", {15'b0, cout, sum}, 32'h10000);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule